// File: doc/BRIEF.md
# Row Write Buffer with Timed Commit

This block sits between a serial memory's bus front end and its storage array. When a write transaction opens, the front end gives it the start address. It then hands over each data byte that has been fully received and acknowledged, and finally a stop strobe. The block holds the bytes in an eight-byte row latch. On the stop strobe it runs a programming cycle of fixed length, and during the first cycles of that cycle it replays the latched bytes to the array as single-byte write requests. A busy flag stays high for the whole programming cycle. While busy is high, every input from the front end is ignored.

The mode pin selects one of two burst modes, and the block samples it when the transaction opens. In row mode only the three low address bits advance, so a long burst wraps inside its eight-byte row and the later bytes overwrite the earlier ones. In sequence mode a burst may start at any address and continue past the end of a row into the next one. It holds four bytes, or eight when it starts on a row boundary. When a sequence-mode burst ends up spanning two rows, the programming cycle doubles. A build parameter selects the variant with hardware write control. That variant has no sequence mode, and its inhibit input suppresses the array writes of a commit.

Top module: `wrbuf_commit`

## Requirements
- R1: With `mode_sel` low when `start` is accepted (row mode), byte k of the burst is placed at address {start_addr[8:3], (start_addr[2:0]+k) mod 8}, so every write stays inside the start row.
- R2: In row mode a burst of more than 8 bytes wraps, and the last byte received for each row position is the one written.
- R3: With `mode_sel` high when `start` is accepted (sequence mode), byte k goes to address start_addr+k (9-bit, may enter the next row). At most 4 bytes are kept when start_addr[2:0] is not 0, and later bytes are dropped.
- R4: In sequence mode with start_addr[2:0] = 0, up to 8 bytes are kept and written to start_addr..start_addr+7.
- R5: A one-byte burst writes exactly that byte at start_addr in either mode.
- R6: A commit begins only on `stop`. `busy` is high in the first cycle after the stop cycle. A stop with no accepted byte, or one with no open transaction, starts no commit.
- R7: `busy` stays high for exactly TPROG_CYC cycles, or 2*TPROG_CYC cycles when the kept bytes of a sequence-mode burst cover two rows (address bits 8..3 differ).
- R8: While `busy` is high, `start`, `byte_valid` and `stop` have no effect: they open no transaction, latch no byte and start no further commit.
- R9: With HW_WC=1, row mode applies whatever `mode_sel` reads. If `wr_inhibit` is high in the stop cycle, the commit runs its full length but issues no write request. With HW_WC=0, `wr_inhibit` is ignored.
- R10: A `byte_valid` in the same cycle as `stop` is part of the burst and is written.
- R11: Write requests are issued only while `busy` is high, at most one per cycle and at most 8 per commit, in ascending row-position order. After reset `busy` and `wr_req` are low.
- R12: A `start` accepted while a transaction is open discards the bytes collected so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a write transaction and loads `start_addr` |
| start_addr | input | AW | First byte address of the burst |
| byte_valid | input | 1 | One completed data byte is on `byte_data` |
| byte_data | input | DW | Data byte |
| stop | input | 1 | Ends the transaction and triggers the commit |
| mode_sel | input | 1 | Burst mode: 0 row mode, 1 sequence mode |
| wr_inhibit | input | 1 | Write-control input, acts only when HW_WC=1 |
| busy | output | 1 | Programming cycle in progress |
| wr_req | output | 1 | Array write strobe |
| wr_addr | output | AW | Array write address |
| wr_data | output | DW | Array write data |

## Verification
The last data byte and the stop strobe can arrive in the same cycle. The block must then fold the byte into the latch and also use the updated byte count to decide that a commit starts. The bench drives both strobes in one cycle. It then expects the full burst to be written and the programming cycle to start on the next cycle. A second collision, a complete new transaction arriving while the commit is still running, is checked by expecting no new write and a busy time of one nominal period.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;

  typedef enum logic {
    MODE_ROW = 1'b0,
    MODE_SEQ = 1'b1
  } burst_mode_e;

endpackage

// File: rtl/wrbuf_collect.sv
module wrbuf_collect
  import wrbuf_pkg::*;
#(
  parameter int AW    = 9,
  parameter int DW    = 8,
  parameter int ROWN  = 8,
  parameter int MMAX  = 4,
  parameter int HW_WC = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  logic             byte_valid,
  input  logic [DW-1:0]    byte_data,
  input  logic             stop,
  input  logic             mode_sel,
  input  logic             wr_inhibit,
  output logic             go,
  output logic             go_long,
  output logic             go_inhibit,
  output logic [AW-1:0]    base,
  output logic             seq_mode,
  output logic [ROWN-1:0]  slot_vld,
  output logic [ROWN*DW-1:0] slot_data
);

  localparam int SW = $clog2(ROWN);
  localparam int CW = $clog2(ROWN + 1);

  logic            active_q, active_d;
  burst_mode_e     mode_q, mode_d;
  logic [AW-1:0]   base_q, base_d;
  logic [SW-1:0]   ptr_q, ptr_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [ROWN-1:0] vld_q, vld_d;
  logic [DW-1:0]   data_q [ROWN];

  logic            st_acc, byte_acc, take, seq_pin;
  logic [CW-1:0]   limit;
  logic [SW-1:0]   slot;
  logic [AW-1:0]   last_addr;

  assign seq_pin = mode_sel & (HW_WC == 0);

  // next-state logic
  always_comb begin
    st_acc   = ~busy & start;
    byte_acc = ~busy & byte_valid & active_q & ~start;
    limit    = (base_q[SW-1:0] == '0) ? CW'(ROWN) : CW'(MMAX);
    take     = byte_acc & ((mode_q == MODE_ROW) | (cnt_q < limit));
    slot     = (mode_q == MODE_SEQ) ? cnt_q[SW-1:0] : ptr_q;

    active_d = active_q;
    mode_d   = mode_q;
    base_d   = base_q;
    ptr_d    = ptr_q;
    cnt_d    = cnt_q;
    vld_d    = vld_q;

    if (st_acc) begin
      active_d = 1'b1;
      mode_d   = seq_pin ? MODE_SEQ : MODE_ROW;
      base_d   = start_addr;
      ptr_d    = start_addr[SW-1:0];
      cnt_d    = '0;
      vld_d    = '0;
    end else begin
      if (take) begin
        ptr_d       = ptr_q + SW'(1);
        vld_d[slot] = 1'b1;
        if (cnt_q != CW'(ROWN)) cnt_d = cnt_q + CW'(1);
      end
      if (~busy & stop) active_d = 1'b0;
    end

    go         = ~busy & stop & active_q & ~start & (cnt_d != '0);
    last_addr  = base_q + AW'(cnt_d) - AW'(1);
    go_long    = (mode_q == MODE_SEQ) & (last_addr[AW-1:SW] != base_q[AW-1:SW]);
    go_inhibit = (HW_WC != 0) & wr_inhibit;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mode_q   <= MODE_ROW;
      base_q   <= '0;
      ptr_q    <= '0;
      cnt_q    <= '0;
      vld_q    <= '0;
    end else begin
      active_q <= active_d;
      mode_q   <= mode_d;
      base_q   <= base_d;
      ptr_q    <= ptr_d;
      cnt_q    <= cnt_d;
      vld_q    <= vld_d;
    end
  end

  // row latch, one register per position, enabled by its slot select
  for (genvar i = 0; i < ROWN; i++) begin : g_slot
    logic wen;
    assign wen = take & (slot == SW'(i));
    always_ff @(posedge clk) begin
      if (wen) data_q[i] <= byte_data;
    end
    assign slot_data[i*DW +: DW] = data_q[i];
  end

  assign base     = base_q;
  assign seq_mode = (mode_q == MODE_SEQ);
  assign slot_vld = vld_q;

endmodule

// File: rtl/wrbuf_sequencer.sv
module wrbuf_sequencer #(
  parameter int AW        = 9,
  parameter int DW        = 8,
  parameter int ROWN      = 8,
  parameter int TPROG_CYC = 1000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               go_long,
  input  logic               go_inhibit,
  input  logic [AW-1:0]      base,
  input  logic               seq_mode,
  input  logic [ROWN-1:0]    slot_vld,
  input  logic [ROWN*DW-1:0] slot_data,
  output logic               busy,
  output logic               wr_req,
  output logic [AW-1:0]      wr_addr,
  output logic [DW-1:0]      wr_data
);

  localparam int SW = $clog2(ROWN);
  localparam int TW = $clog2(2 * TPROG_CYC + 1);

  logic          busy_q, busy_d;
  logic          inh_q, inh_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [SW:0]   idx_q, idx_d;
  logic [SW-1:0] pos;
  logic          idx_live;

  assign pos      = idx_q[SW-1:0];
  assign idx_live = busy_q & ~idx_q[SW];

  // next-state logic
  always_comb begin
    busy_d = busy_q;
    inh_d  = inh_q;
    tmr_d  = tmr_q;
    idx_d  = idx_q;
    if (go) begin
      busy_d = 1'b1;
      inh_d  = go_inhibit;
      tmr_d  = go_long ? TW'(2 * TPROG_CYC - 1) : TW'(TPROG_CYC - 1);
      idx_d  = '0;
    end else if (busy_q) begin
      if (tmr_q == '0) busy_d = 1'b0;
      else             tmr_d  = tmr_q - TW'(1);
      if (idx_live)    idx_d  = idx_q + (SW+1)'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      inh_q  <= 1'b0;
      tmr_q  <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      inh_q  <= inh_d;
      tmr_q  <= tmr_d;
      idx_q  <= idx_d;
    end
  end

  assign busy    = busy_q;
  assign wr_req  = idx_live & slot_vld[pos] & ~inh_q;
  assign wr_addr = seq_mode ? (base + AW'(pos)) : {base[AW-1:SW], pos};
  assign wr_data = slot_data[pos*DW +: DW];

endmodule

// File: rtl/wrbuf_commit.sv
module wrbuf_commit #(
  parameter int AW        = 9,
  parameter int DW        = 8,
  parameter int ROWN      = 8,
  parameter int MMAX      = 4,
  parameter int TPROG_CYC = 1000000,
  parameter int HW_WC     = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_data,
  input  logic          stop,
  input  logic          mode_sel,
  input  logic          wr_inhibit,
  output logic          busy,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  logic               go, go_long, go_inhibit, seq_mode;
  logic [AW-1:0]      base;
  logic [ROWN-1:0]    slot_vld;
  logic [ROWN*DW-1:0] slot_data;

  wrbuf_collect #(
    .AW(AW), .DW(DW), .ROWN(ROWN), .MMAX(MMAX), .HW_WC(HW_WC)
  ) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .start      (start),
    .start_addr (start_addr),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .stop       (stop),
    .mode_sel   (mode_sel),
    .wr_inhibit (wr_inhibit),
    .go         (go),
    .go_long    (go_long),
    .go_inhibit (go_inhibit),
    .base       (base),
    .seq_mode   (seq_mode),
    .slot_vld   (slot_vld),
    .slot_data  (slot_data)
  );

  wrbuf_sequencer #(
    .AW(AW), .DW(DW), .ROWN(ROWN), .TPROG_CYC(TPROG_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .go_long    (go_long),
    .go_inhibit (go_inhibit),
    .base       (base),
    .seq_mode   (seq_mode),
    .slot_vld   (slot_vld),
    .slot_data  (slot_data),
    .busy       (busy),
    .wr_req     (wr_req),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

endmodule

// File: rtl/wrbuf_chk.sv
module wrbuf_chk #(
  parameter int ROWN      = 8,
  parameter int TPROG_CYC = 1000000
) (
  input logic clk,
  input logic rst_n,
  input logic stop,
  input logic busy,
  input logic wr_req
);

  localparam int TW = $clog2(2 * TPROG_CYC + 1) + 1;
  localparam int NW = $clog2(ROWN + 1) + 1;

  logic [TW-1:0] run_q;
  logic [NW-1:0] nwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      nwr_q <= '0;
    end else begin
      run_q <= busy ? run_q + TW'(1) : '0;
      nwr_q <= busy ? nwr_q + NW'(wr_req) : '0;
    end
  end

  // R11
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> busy);

  // R6
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));

  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < TW'(2 * TPROG_CYC)));

  // R11
  req_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (nwr_q < NW'(ROWN)));

endmodule

bind wrbuf_commit wrbuf_chk #(.ROWN(ROWN), .TPROG_CYC(TPROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .busy(busy), .wr_req(wr_req)
);

// File: tb/sim_wrbuf_commit.sv
`timescale 1ns/1ps
module sim_wrbuf_commit;

  localparam int AW = 9;
  localparam int DW = 8;
  localparam int TP = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, byte_valid = 1'b0, stop = 1'b0;
  logic          mode_sel = 1'b0, wr_inhibit = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] byte_data = '0;

  logic          busy0, wr0, busy1, wr1;
  logic [AW-1:0] addr0, addr1;
  logic [DW-1:0] data0, data1;

  int checks = 0, fails = 0;
  int n0 = 0, n1 = 0, bc0 = 0, bc1 = 0;
  int la0 [32], ld0 [32], la1 [32], ld1 [32];

  always #2.5 clk = ~clk;

  wrbuf_commit #(.TPROG_CYC(TP), .HW_WC(0)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop(stop),
    .mode_sel(mode_sel), .wr_inhibit(wr_inhibit),
    .busy(busy0), .wr_req(wr0), .wr_addr(addr0), .wr_data(data0));

  wrbuf_commit #(.TPROG_CYC(TP), .HW_WC(1)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop(stop),
    .mode_sel(mode_sel), .wr_inhibit(wr_inhibit),
    .busy(busy1), .wr_req(wr1), .wr_addr(addr1), .wr_data(data1));

  // observe outputs mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy0) bc0++;
      if (busy1) bc1++;
      if (wr0) begin
        if (n0 < 32) begin la0[n0] = int'(addr0); ld0[n0] = int'(data0); end
        n0++;
      end
      if (wr1) begin
        if (n1 < 32) begin la1[n1] = int'(addr1); ld1[n1] = int'(data1); end
        n1++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    n0 = 0; n1 = 0; bc0 = 0; bc1 = 0;
  endtask

  task automatic burst(input int addr, input int n, input logic md,
                       input int d0, input bit merge);
    @(negedge clk);
    start = 1'b1; start_addr = AW'(addr); mode_sel = md;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      byte_valid = 1'b1;
      byte_data  = DW'(d0 + k);
      if (merge && k == n - 1) stop = 1'b1;
      @(negedge clk);
    end
    byte_valid = 1'b0;
    if (!(merge && n > 0)) begin
      stop = 1'b1;
      @(negedge clk);
    end
    stop = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2 * TP + 12) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset busy", int'(busy0), 0);
    chk("R11 reset wr_req", int'(wr0), 0);
  endtask

  task automatic t_row_basic();
    clear_logs();
    burst(32'h105, 3, 1'b0, 32'hA0, 1'b0);
    chk("R6 busy after stop", int'(busy0), 1);
    wait_idle();
    chk("R1 write count", n0, 3);
    for (int j = 0; j < 3; j++) begin
      chk("R1 addr", la0[j], 32'h105 + j);
      chk("R1 data", ld0[j], 32'hA0 + j);
    end
    chk("R7 nominal busy", bc0, TP);
  endtask

  task automatic t_row_wrap();
    clear_logs();
    burst(32'h0E, 10, 1'b0, 32'h10, 1'b0);
    wait_idle();
    chk("R2 write count", n0, 8);
    for (int j = 0; j < 8; j++) begin
      chk("R2 addr", la0[j], 32'h08 + j);
      chk("R2 data", ld0[j], 32'h12 + j);
    end
  endtask

  task automatic t_seq_cross();
    clear_logs();
    burst(32'h0E, 4, 1'b1, 32'h40, 1'b0);
    wait_idle();
    chk("R3 write count", n0, 4);
    for (int j = 0; j < 4; j++) begin
      chk("R3 addr", la0[j], 32'h0E + j);
      chk("R3 data", ld0[j], 32'h40 + j);
    end
    chk("R7 doubled busy", bc0, 2 * TP);
    chk("R9 variant count", n1, 4);
    chk("R9 variant addr0", la1[0], 32'h08);
    chk("R9 variant data0", ld1[0], 32'h42);
    chk("R9 variant addr2", la1[2], 32'h0E);
    chk("R9 variant data3", ld1[3], 32'h41);
    chk("R9 variant busy", bc1, TP);
  endtask

  task automatic t_seq_extra();
    clear_logs();
    burst(32'h21, 6, 1'b1, 32'h50, 1'b0);
    wait_idle();
    chk("R3 extra dropped count", n0, 4);
    chk("R3 extra last addr", la0[3], 32'h24);
    chk("R3 extra last data", ld0[3], 32'h53);
    chk("R7 one-row busy", bc0, TP);
  endtask

  task automatic t_seq_full();
    clear_logs();
    burst(32'h30, 8, 1'b1, 32'h60, 1'b0);
    wait_idle();
    chk("R4 write count", n0, 8);
    for (int j = 0; j < 8; j++) begin
      chk("R4 addr", la0[j], 32'h30 + j);
      chk("R4 data", ld0[j], 32'h60 + j);
    end
    chk("R4 busy", bc0, TP);
  endtask

  task automatic t_single();
    for (int m = 0; m < 2; m++) begin
      clear_logs();
      burst(32'h1FF, 1, logic'(m), 32'h77, 1'b0);
      wait_idle();
      chk("R5 count", n0, 1);
      chk("R5 addr", la0[0], 32'h1FF);
      chk("R5 data", ld0[0], 32'h77);
      chk("R5 busy", bc0, TP);
    end
  endtask

  task automatic t_empty();
    clear_logs();
    burst(32'h44, 0, 1'b0, 0, 1'b0);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    wait_idle();
    chk("R6 empty busy", bc0, 0);
    chk("R6 empty writes", n0, 0);
  endtask

  task automatic t_ignore();
    clear_logs();
    burst(32'h40, 2, 1'b0, 32'hC0, 1'b0);
    burst(32'h80, 3, 1'b0, 32'hD0, 1'b0);
    wait_idle();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    wait_idle();
    chk("R8 writes", n0, 2);
    chk("R8 addr", la0[1], 32'h41);
    chk("R8 data", ld0[1], 32'hC1);
    chk("R8 busy", bc0, TP);
  endtask

  task automatic t_same_cycle();
    clear_logs();
    burst(32'h50, 2, 1'b0, 32'hE0, 1'b1);
    chk("R10 busy next cycle", int'(busy0), 1);
    wait_idle();
    chk("R10 count", n0, 2);
    chk("R10 addr", la0[1], 32'h51);
    chk("R10 data", ld0[1], 32'hE1);
  endtask

  task automatic t_inhibit();
    clear_logs();
    wr_inhibit = 1'b1;
    burst(32'h60, 2, 1'b0, 32'h90, 1'b0);
    wait_idle();
    wr_inhibit = 1'b0;
    chk("R9 inhibit writes", n1, 0);
    chk("R9 inhibit busy", bc1, TP);
    chk("R9 no-effect writes", n0, 2);
  endtask

  task automatic t_restart();
    clear_logs();
    @(negedge clk); start = 1'b1; start_addr = 9'h070; mode_sel = 1'b0;
    @(negedge clk); start = 1'b0; byte_valid = 1'b1; byte_data = 8'h11;
    @(negedge clk); byte_data = 8'h12;
    @(negedge clk); byte_valid = 1'b0;
    burst(32'h90, 1, 1'b0, 32'hAA, 1'b0);
    wait_idle();
    chk("R12 count", n0, 1);
    chk("R12 addr", la0[0], 32'h90);
    chk("R12 data", ld0[0], 32'hAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_row_basic();
    t_row_wrap();
    t_seq_cross();
    t_seq_extra();
    t_seq_full();
    t_single();
    t_empty();
    t_ignore();
    t_same_cycle();
    t_inhibit();
    t_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule